// File: doc/BRIEF.md
# Framed Receive Buffer with Word Readout

This block is the receive store of a small Ethernet MAC. Received frames arrive one byte per cycle. Each accepted frame is written into a single byte-wide circular buffer, wrapped in a fixed layout. The layout starts with a constant marker word and a header word that gives the stored length and a good-status code. The frame bytes follow, zero-padded up to the minimum frame size. After them come a CRC-32 over the data and padding, then zero bytes up to the next 32-bit boundary.

The host empties the buffer one 32-bit word per read strobe. A readout sequencer knows whether the next word is the marker, the header or frame content. It keeps a count of complete frames still held, and the host can read that count. A new frame is taken only when the buffer has room for a largest frame. A frame that arrives without that room is discarded as a whole and a sticky overflow flag is raised. Writing zero to the count register throws away every buffered frame.

Top module: `rx_frame_fifo`

## Requirements
- R1: `in_ready` is high only when `rx_enable` is high, the write sequencer is idle and at least 1532 bytes of the buffer are unused. A frame whose first byte arrives while `in_ready` is high is stored.
- R2: A frame whose first byte arrives while `in_ready` is low is discarded completely and `frame_count` does not change. If `rx_enable` was high at that byte, `overflow` goes high and stays high until a flush.
- R3: Each stored frame begins with two words. The first is the marker 32'h01434D52. The second is the header: bits 15:0 hold the padded length plus 4 and bits 31:16 hold the status 16'h0001. Every word is stored least significant byte first, so a data read returns it unchanged.
- R4: A frame shorter than 60 bytes is followed by zero bytes up to 60 bytes. A frame of 60 bytes or more is stored unpadded.
- R5: After the padded frame comes the CRC-32, stored least significant byte first. It uses reflected polynomial 32'hEDB88320, starts from all ones and is complemented at the end. It is computed over the frame bytes and the zero padding. Zero bytes then follow up to the next 4-byte boundary.
- R6: Once a frame is completely stored, `frame_count` goes up by one and `irq_status` is set. A pulse on `irq_clear` clears `irq_status`.
- R7: A read with `rd_en` returns the next buffered word on `rd_data` in the same cycle. After the header read, the number of content bytes still to come is the header's low 16 bits rounded up to a multiple of 4. Each later read lowers it by 4. The read that brings it to zero ends the frame: `frame_count` drops by one and the next read returns a marker.
- R8: A read while `frame_count` is 0 returns 0 and changes no state.
- R9: Writing 0 with `cnt_wr` empties all stored frames and clears `frame_count`, the read position and `overflow`. Writing a non-zero value has no effect.
- R10: Several frames can be buffered at once. They are read out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable |
| in_valid | input | 1 | Incoming frame byte valid |
| in_data | input | 8 | Incoming frame byte (at most 1518 per frame) |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Room for a new frame |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 32 | Data register read value |
| frame_count | output | CW (6) | Complete frames buffered |
| cnt_wr | input | 1 | Frame-count register write strobe |
| cnt_wr_data | input | 32 | Frame-count register write value |
| irq_status | output | 1 | Frame received status bit |
| irq_clear | input | 1 | Clears `irq_status` |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
The properties assume that a new frame starts only when `in_ready` is high or is meant to be dropped as a whole. They also assume that `in_valid` bytes of one frame end with exactly one `in_last`, and that no frame has more than 1518 bytes. The stimulus holds to all of this. It sends each frame on consecutive cycles with `in_last` on its final byte. It waits until the previous frame has been committed before offering the next one. Frame lengths stay between 10 and 1518 bytes. Drops are provoked on purpose in two ways: with receive disabled, and with the buffer too full after a largest frame.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int          DEPTH   = 2048,
  parameter int          MIN_LEN = 60,
  parameter int          MAX_LEN = 1518,
  parameter int          ROOM    = 1532,
  parameter logic [31:0] MAGIC   = 32'h0143_4D52,
  parameter logic [15:0] STAT_OK = 16'h0001,
  localparam int         CW      = $clog2(DEPTH / 64) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] frame_count,
  input  logic          cnt_wr,
  input  logic [31:0]   cnt_wr_data,
  output logic          irq_status,
  input  logic          irq_clear,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(MAX_LEN + 8) + 1;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_DROP, S_PAD, S_CRC, S_ALIGN, S_HDR} wstate_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  logic [7:0]    mem [DEPTH];
  wstate_t       state;
  logic [AW:0]   wp, rp, used;
  logic [LW-1:0] off, plen;
  logic [2:0]    idx;
  logic [31:0]   crc, crc_fin, rd_word;
  logic [63:0]   hdr_pair;
  logic          we, commit, flush, rd_fire, done;
  logic [AW-1:0] wa;
  logic [7:0]    wd;
  logic [1:0]    phase;
  logic [16:0]   remain, hdr_round;

  assign used     = wp - rp;
  assign in_ready = rx_enable && state == S_IDLE && (32'(used) + ROOM <= DEPTH);
  assign crc_fin  = ~crc;
  assign hdr_pair = {STAT_OK, 16'(plen + LW'(4)), MAGIC};
  assign commit   = state == S_HDR && idx == 3'd7;
  assign flush    = cnt_wr && cnt_wr_data == 32'd0;

  always_comb begin
    we = 1'b0;
    wa = wp[AW-1:0] + AW'(8) + AW'(off);
    wd = 8'h00;
    case (state)
      S_IDLE:  if (in_valid && in_ready) begin we = 1'b1; wd = in_data; end
      S_DATA:  if (in_valid && off < LW'(MAX_LEN)) begin we = 1'b1; wd = in_data; end
      S_PAD:   we = off < LW'(MIN_LEN);
      S_CRC:   begin we = 1'b1; wd = 8'(crc_fin >> {idx[1:0], 3'b000}); end
      S_ALIGN: we = off[1:0] != 2'b00;
      S_HDR:   begin we = 1'b1; wa = wp[AW-1:0] + AW'(idx); wd = 8'(hdr_pair >> {idx, 3'b000}); end
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) if (we) mem[wa] <= wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wp    <= '0;
      off   <= '0;
      plen  <= '0;
      idx   <= '0;
      crc   <= '1;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          if (in_ready) begin
            crc   <= crc_step(32'hFFFF_FFFF, in_data);
            off   <= LW'(1);
            state <= in_last ? S_PAD : S_DATA;
          end else if (!in_last) state <= S_DROP;
        end
        S_DATA: if (in_valid) begin
          if (off < LW'(MAX_LEN)) begin
            crc <= crc_step(crc, in_data);
            off <= off + LW'(1);
          end
          if (in_last) state <= S_PAD;
        end
        S_DROP: if (in_valid && in_last) state <= S_IDLE;
        S_PAD: begin
          if (off < LW'(MIN_LEN)) begin
            crc <= crc_step(crc, 8'h00);
            off <= off + LW'(1);
          end else begin
            plen  <= off;
            idx   <= '0;
            state <= S_CRC;
          end
        end
        S_CRC: begin
          off <= off + LW'(1);
          idx <= idx + 3'd1;
          if (idx == 3'd3) begin idx <= '0; state <= S_ALIGN; end
        end
        S_ALIGN: if (off[1:0] != 2'b00) off <= off + LW'(1); else state <= S_HDR;
        S_HDR: begin
          idx <= idx + 3'd1;
          if (idx == 3'd7) begin
            wp    <= wp + (AW+1)'(8) + (AW+1)'(off);
            off   <= '0;
            idx   <= '0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_word   = {mem[rp[AW-1:0] + AW'(3)], mem[rp[AW-1:0] + AW'(2)],
                      mem[rp[AW-1:0] + AW'(1)], mem[rp[AW-1:0]]};
  assign rd_data   = frame_count != '0 ? rd_word : 32'd0;
  assign rd_fire   = rd_en && frame_count != '0 && !flush;
  assign done      = rd_fire && phase == 2'd2 && remain == 17'd4;
  assign hdr_round = ({1'b0, rd_word[15:0]} + 17'd3) & ~17'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp          <= '0;
      phase       <= '0;
      remain      <= '0;
      frame_count <= '0;
      irq_status  <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      if (flush) begin
        rp          <= wp;
        phase       <= '0;
        remain      <= '0;
        frame_count <= commit ? CW'(1) : '0;
      end else begin
        frame_count <= frame_count + CW'(commit) - CW'(done);
        if (rd_fire) begin
          rp <= rp + (AW+1)'(4);
          case (phase)
            2'd0: phase <= 2'd1;
            2'd1: begin phase <= 2'd2; remain <= hdr_round; end
            default: begin
              remain <= remain - 17'd4;
              if (remain == 17'd4) phase <= 2'd0;
            end
          endcase
        end
      end
      if (commit) irq_status <= 1'b1;
      else if (irq_clear) irq_status <= 1'b0;
      if (flush) overflow <= 1'b0;
      else if (state == S_IDLE && in_valid && !in_ready && rx_enable) overflow <= 1'b1;
    end
  end

  // R1
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used) <= DEPTH);
  // R2
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && in_valid && !in_ready |=> $stable(wp) && state != S_DATA);
  // R6
  commit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq_status && frame_count != '0);
  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && phase == 2'd2 && remain == 17'd4 |=> phase == 2'd0);
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && frame_count == '0 && !flush |=> $stable(rp) && $stable(phase));
  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !commit |=> frame_count == '0 && phase == 2'd0 && !overflow);
endmodule

// File: tb/rx_frame_fifo_bench.sv
module rx_frame_fifo_bench;
  localparam int          DEPTH = 2048;
  localparam int          ROOM  = 1532;
  localparam int          CW    = 6;
  localparam logic [31:0] MAGIC = 32'h0143_4D52;
  localparam logic [15:0] STAT  = 16'h0001;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, rx_enable = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic rd_en = 1'b0, cnt_wr = 1'b0, irq_clear = 1'b0;
  logic [31:0] cnt_wr_data = 32'd0;
  logic in_ready, irq_status, overflow;
  logic [31:0] rd_data;
  logic [CW-1:0] frame_count;

  rx_frame_fifo u_rx_frame_fifo (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .rd_en(rd_en),
    .rd_data(rd_data), .frame_count(frame_count), .cnt_wr(cnt_wr),
    .cnt_wr_data(cnt_wr_data), .irq_status(irq_status), .irq_clear(irq_clear),
    .overflow(overflow));

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;
  byte unsigned mq[$];
  int m_cnt = 0, m_phase = 0, m_remain = 0;
  bit m_irq = 1'b0, m_ovf = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(frame_count == CW'(m_cnt), "R7", 32'(frame_count), 32'(m_cnt), "frame count");
      check(irq_status == m_irq, "R6", 32'(irq_status), 32'(m_irq), "irq status");
      check(overflow == m_ovf, "R2", 32'(overflow), 32'(m_ovf), "overflow flag");
    end
  end

  function automatic logic [31:0] crc_of(input byte unsigned b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c = c ^ 32'(b[i]);
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) mq.push_back(8'(w >> (8 * k)));
  endtask

  task automatic send(input int n, input int seed);
    byte unsigned d[$];
    bit exp_rdy;
    int t, plen;
    logic [31:0] c;
    cmp_on = 1'b0;
    @(negedge clk);
    exp_rdy = rx_enable && (DEPTH - mq.size() >= ROOM);
    check(in_ready == exp_rdy, "R1", 32'(in_ready), 32'(exp_rdy), "ready before frame");
    for (int i = 0; i < n; i++) begin
      d.push_back(8'(seed + i * 7));
      in_valid = 1'b1;
      in_data  = d[i];
      in_last  = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (exp_rdy) begin
      t = 0;
      while (frame_count == CW'(m_cnt) && t < 300) begin @(negedge clk); t++; end
      check(t < 300, "R6", 32'(t), 32'd300, "frame commit wait");
      plen = n < 60 ? 60 : n;
      while (d.size() < plen) d.push_back(8'h00);
      c = crc_of(d);
      push_word(MAGIC);
      push_word({STAT, 16'(plen + 4)});
      foreach (d[i]) mq.push_back(d[i]);
      push_word(c);
      for (int i = 0; i < (4 - plen % 4) % 4; i++) mq.push_back(8'h00);
      m_cnt++;
      m_irq = 1'b1;
    end else begin
      repeat (20) @(negedge clk);
      if (rx_enable) m_ovf = 1'b1;
    end
    cmp_on = 1'b1;
  endtask

  task automatic read_word(input string req);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    e = 32'd0;
    if (m_cnt != 0) e = {mq[3], mq[2], mq[1], mq[0]};
    check(rd_data == e, req, rd_data, e, "data word");
    @(posedge clk);
    #1 rd_en = 1'b0;
    if (m_cnt != 0) begin
      repeat (4) void'(mq.pop_front());
      case (m_phase)
        0: m_phase = 1;
        1: begin m_phase = 2; m_remain = (int'(e[15:0]) + 3) / 4 * 4; end
        default: begin
          m_remain -= 4;
          if (m_remain == 0) begin m_phase = 0; m_cnt--; end
        end
      endcase
    end
  endtask

  task automatic read_frame(input string req);
    read_word(req);
    while (m_phase != 0) read_word(req);
  endtask

  task automatic write_cnt(input logic [31:0] v);
    @(negedge clk);
    cnt_wr = 1'b1;
    cnt_wr_data = v;
    @(posedge clk);
    #1 cnt_wr = 1'b0;
    if (v == 32'd0) begin
      mq.delete();
      m_cnt = 0; m_phase = 0; m_remain = 0; m_ovf = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(frame_count == '0, "R7", 32'(frame_count), 0, "reset count");
    check(!irq_status, "R6", 32'(irq_status), 0, "reset irq");
    check(!overflow, "R2", 32'(overflow), 0, "reset overflow");
    check(!in_ready, "R1", 32'(in_ready), 0, "ready while disabled");
    check(rd_data == 32'd0, "R8", rd_data, 0, "reset data");
    cmp_on = 1'b1;

    read_word("R8");
    send(20, 1);
    @(negedge clk) rx_enable = 1'b1;
    @(negedge clk) #1;
    check(in_ready, "R1", 32'(in_ready), 1, "ready when enabled");

    send(10, 3);
    read_frame("R4");
    @(negedge clk) irq_clear = 1'b1;
    @(posedge clk) #1 irq_clear = 1'b0;
    m_irq = 1'b0;
    @(negedge clk) #1;
    check(!irq_status, "R6", 32'(irq_status), 0, "irq cleared");

    send(61, 5);
    send(64, 9);
    check(frame_count == CW'(2), "R10", 32'(frame_count), 2, "two frames held");
    read_frame("R10");
    read_frame("R5");
    send(60, 11);
    read_frame("R3");

    send(1518, 13);
    @(negedge clk) #1;
    check(!in_ready, "R1", 32'(in_ready), 0, "ready with buffer near full");
    send(20, 17);
    check(overflow, "R2", 32'(overflow), 1, "overflow after drop");
    check(frame_count == CW'(1), "R2", 32'(frame_count), 1, "count after drop");
    read_frame("R7");
    @(negedge clk) #1;
    check(in_ready, "R1", 32'(in_ready), 1, "ready after drain");

    send(30, 19);
    read_word("R7");
    read_word("R7");
    read_word("R7");
    write_cnt(32'd5);
    @(negedge clk) #1;
    check(frame_count == CW'(1), "R9", 32'(frame_count), 1, "nonzero write ignored");
    read_word("R9");
    write_cnt(32'd0);
    @(negedge clk) #1;
    check(frame_count == '0, "R9", 32'(frame_count), 0, "count after flush");
    check(!overflow, "R9", 32'(overflow), 0, "overflow after flush");
    read_word("R8");
    send(12, 23);
    read_frame("R9");
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule